// File: doc/BRIEF.md
# Ultra DMA Write Burst Termination Sequencer

This block is the host-side end-of-burst controller for an ATA Ultra DMA write. A start pulse latches the transfer mode (0 to 5) and the sector count, then the sequencer holds the device acknowledge and the select/address lines asserted while the data mover reports each 16-bit word it has sent. Once the byte total reaches the sector count times 512, the sequencer winds the burst down in a fixed order. It negates the write strobe and waits for the device to drop both its request and its ready lines. It then drives the host CRC word onto the bus and negates the acknowledge after a mode-dependent delay, keeps the CRC on the bus for a short hold, and finally releases the selects and address with a one-cycle done pulse.

All nanosecond limits are turned into clock cycles at elaboration time, rounding up, from a clock-period parameter. The CRC computation, read bursts and the word transfers themselves happen elsewhere. The block only sees a pulse per word and the CRC value to present.

Top module: `udma_wr_term`

## Requirements
- R1: Out of reset and whenever idle, `wr_stb_n_o`, `ack_n_o`, `sel0_n_o` and `sel1_n_o` are 1, `addr_o`, `dout_o`, `dout_oe_o` and `done_o` are 0.
- R2: A `start_i` pulse sampled while idle latches `mode_i` and `sec_cnt_i`. From the next cycle on, `ack_n_o`, `sel0_n_o` and `sel1_n_o` are 0 and `addr_o` equals `HA_HOLD` (default 5) until release. A `start_i` pulse during a burst has no effect.
- R3: With a nonzero sector count, `wr_stb_n_o` is 0 during the data phase. It goes to 1 in the cycle after the `word_sent_i` pulse that brings the byte total (2 bytes per pulse) to sector count × 512. With a sector count of 0, `wr_stb_n_o` stays 1 and the block goes straight to waiting on the device. Word pulses outside the data phase are ignored.
- R4: After the strobe stops, the block waits while `dev_req_i` or `dev_rdy_i` is 1. In the cycle after both are sampled 0, `dout_oe_o` is 1 and `dout_o` carries the `crc_i` value sampled at that edge.
- R5: `ack_n_o` rises after `dout_oe_o` has been 1 for exactly max(ceil(Tsetup/P), ceil(Treq/P)) cycles, where P is `CLK_PERIOD_NS`. Tsetup is 100/90/70/60/40/30 ns and Treq is 140/130/110/100/80/70 ns for modes 0/1/2/3/4/5.
- R6: A latched mode of 6 or 7 uses the mode 0 timing.
- R7: `dout_oe_o` and the CRC on `dout_o` stay for ceil(20/P) cycles after `ack_n_o` rises, after which `dout_o` returns to 0.
- R8: The selects and address are released max(ceil(30/P), ceil(20/P)) cycles after `ack_n_o` rises. `done_o` is 1 for exactly that first released cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Burst start pulse |
| mode_i | input | 3 | Ultra DMA mode, latched at start |
| sec_cnt_i | input | SEC_W | Sector count, latched at start |
| word_sent_i | input | 1 | One pulse per 16-bit word sent |
| dev_req_i | input | 1 | Device DMA request, high active |
| dev_rdy_i | input | 1 | Device ready/strobe line, high active |
| crc_i | input | DATA_W | Host CRC word to present |
| wr_stb_n_o | output | 1 | Write strobe stop control (1 = stopped) |
| ack_n_o | output | 1 | DMA acknowledge, low active |
| sel0_n_o | output | 1 | Chip select 0, low active |
| sel1_n_o | output | 1 | Chip select 1, low active |
| addr_o | output | ADDR_W | Register address lines |
| dout_o | output | DATA_W | Data bus output value |
| dout_oe_o | output | 1 | Data bus output enable |
| done_o | output | 1 | One-cycle termination complete pulse |

## Verification
The embedded properties assume that `start_i` arrives only while the block is idle or is meant to be ignored, and that `word_sent_i` is a single-cycle pulse at most once per clock. They also assume the device lines are synchronous to `clk`. The bench drives every input at the falling edge, so each one is stable for a full cycle around the sampling edge. It pulses words with and without idle gaps, releases the request and ready lines at separate, staggered times, and changes `crc_i` while the block waits. It also issues stray start and word pulses only in phases where the requirements say they are ignored.

// File: rtl/udma_term_pkg.sv
package udma_term_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DATA,
      ST_DRAIN,
      ST_CRC,
      ST_POST
   } term_state_e;

   localparam int unsigned CRC_HOLD_NS = 20;
   localparam int unsigned SEL_REL_NS  = 30;

   // Ceiling conversion of a time to whole clock periods.
   function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
      return (ns + per - 1) / per;
   endfunction

   // CRC valid time before acknowledge negation; unknown modes fall back to mode 0.
   function automatic int unsigned crc_setup_ns(input logic [2:0] m);
      case (m)
         3'd5:    return 30;
         3'd4:    return 40;
         3'd3:    return 60;
         3'd2:    return 70;
         3'd1:    return 90;
         default: return 100;
      endcase
   endfunction

   // Request-low to acknowledge-high minimum; unknown modes fall back to mode 0.
   function automatic int unsigned req_ack_ns(input logic [2:0] m);
      case (m)
         3'd5:    return 70;
         3'd4:    return 80;
         3'd3:    return 100;
         3'd2:    return 110;
         3'd1:    return 130;
         default: return 140;
      endcase
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/udma_mode_timing.sv
module udma_mode_timing
   import udma_term_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_NS = 20,
   parameter int unsigned CNT_W         = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [2:0]       mode_i,
   output logic [CNT_W-1:0] pre_cyc_o
);

   localparam int unsigned NUM_CODES = 8;

   logic [2:0]       mode_q;
   logic [CNT_W-1:0] pre_tbl [NUM_CODES];

   // One table entry per mode code, each the longer of the two pre-negation limits.
   for (genvar m = 0; m < NUM_CODES; m++) begin : g_code
      localparam int unsigned SU  = ns2cyc(crc_setup_ns(3'(m)), CLK_PERIOD_NS);
      localparam int unsigned RQ  = ns2cyc(req_ack_ns(3'(m)), CLK_PERIOD_NS);
      localparam int unsigned PRE = umax(SU, RQ);
      if (PRE >= (1 << CNT_W)) begin : g_too_narrow
         $error("udma_mode_timing: CNT_W too small for mode %0d", m);
      end
      assign pre_tbl[m] = CNT_W'(PRE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 3'd0;
      end else if (load_i) begin
         mode_q <= mode_i;
      end
   end

   assign pre_cyc_o = pre_tbl[mode_q];

endmodule

// File: rtl/udma_byte_counter.sv
module udma_byte_counter #(
   parameter int unsigned SEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [SEC_W-1:0] sec_i,
   input  logic             en_i,
   input  logic             word_i,
   output logic             last_o,
   output logic             empty_o
);

   localparam int unsigned SEC_SHIFT = 9;
   localparam int unsigned BYTE_W    = SEC_W + SEC_SHIFT + 1;

   if (SEC_W < 1) begin : g_bad_sec
      $error("udma_byte_counter: SEC_W must be at least 1");
   end

   logic [SEC_W-1:0]  sec_q;
   logic [BYTE_W-1:0] bytes_q;
   logic [BYTE_W-1:0] bytes_nx;
   logic [BYTE_W-1:0] target;

   assign target   = {1'b0, sec_q, {SEC_SHIFT{1'b0}}};
   assign bytes_nx = bytes_q + BYTE_W'(2);
   assign last_o   = en_i && word_i && (bytes_nx == target);
   assign empty_o  = (sec_i == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q   <= '0;
         bytes_q <= '0;
      end else if (clr_i) begin
         sec_q   <= sec_i;
         bytes_q <= '0;
      end else if (en_i && word_i) begin
         bytes_q <= bytes_nx;
      end
   end

   // R3
   byte_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |-> (bytes_q < target));

endmodule

// File: rtl/udma_term_fsm.sv
module udma_term_fsm
   import udma_term_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned CNT_W    = 3,
   parameter int unsigned HOLD_CYC = 1,
   parameter int unsigned POST_CYC = 2,
   parameter int unsigned HA_HOLD  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              empty_i,
   input  logic              last_i,
   input  logic              dev_req_i,
   input  logic              dev_rdy_i,
   input  logic [DATA_W-1:0] crc_i,
   input  logic [CNT_W-1:0]  pre_cyc_i,
   output logic              load_o,
   output logic              data_en_o,
   output logic              wr_stb_n_o,
   output logic              ack_n_o,
   output logic              sel0_n_o,
   output logic              sel1_n_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] dout_o,
   output logic              dout_oe_o,
   output logic              done_o
);

   localparam logic [CNT_W-1:0]  HOLD_C    = CNT_W'(HOLD_CYC);
   localparam logic [CNT_W-1:0]  POST_LAST = CNT_W'(POST_CYC - 1);
   localparam logic [ADDR_W-1:0] ADDR_HELD = ADDR_W'(HA_HOLD);

   if (HOLD_CYC < 1 || POST_CYC < HOLD_CYC) begin : g_bad_post
      $error("udma_term_fsm: post-acknowledge window shorter than CRC hold");
   end
   if (POST_CYC >= (1 << CNT_W)) begin : g_bad_cnt
      $error("udma_term_fsm: CNT_W too small for post window");
   end

   term_state_e       state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] crc_q;
   logic              done_q;
   logic              busy;
   logic              dev_quiet;

   assign dev_quiet = !dev_req_i && !dev_rdy_i;
   assign load_o    = start_i && (state_q == ST_IDLE);
   assign data_en_o = (state_q == ST_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         crc_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= empty_i ? ST_DRAIN : ST_DATA;
               end
            end
            ST_DATA: begin
               if (last_i) begin
                  state_q <= ST_DRAIN;
               end
            end
            ST_DRAIN: begin
               if (dev_quiet) begin
                  crc_q   <= crc_i;
                  cnt_q   <= pre_cyc_i - CNT_W'(1);
                  state_q <= ST_CRC;
               end
            end
            ST_CRC: begin
               if (cnt_q == '0) begin
                  state_q <= ST_POST;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            ST_POST: begin
               if (cnt_q == POST_LAST) begin
                  state_q <= ST_IDLE;
                  cnt_q   <= '0;
                  done_q  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != ST_IDLE);
   assign wr_stb_n_o = (state_q != ST_DATA);
   assign ack_n_o    = !((state_q == ST_DATA) || (state_q == ST_DRAIN) || (state_q == ST_CRC));
   assign sel0_n_o   = !busy;
   assign sel1_n_o   = !busy;
   assign addr_o     = busy ? ADDR_HELD : '0;
   assign dout_oe_o  = (state_q == ST_CRC) || ((state_q == ST_POST) && (cnt_q < HOLD_C));
   assign dout_o     = dout_oe_o ? crc_q : '0;
   assign done_o     = done_q;

   // R2
   start_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (state_q == ST_IDLE)) |=> !ack_n_o);

   // R3
   strobe_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_stb_n_o) |-> !ack_n_o);

   // R4
   crc_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_oe_o) |-> $past(!dev_req_i && !dev_rdy_i));

   // R5
   ack_over_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_n_o) |-> (dout_oe_o && $past(dout_oe_o)));

   // R7
   hold_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dout_oe_o) |-> ack_n_o);

   // R8
   release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel0_n_o) |-> (done_o && ack_n_o && !dout_oe_o));

endmodule

// File: rtl/udma_wr_term.sv
module udma_wr_term
   import udma_term_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_NS = 20,
   parameter int unsigned SEC_W         = 8,
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned ADDR_W        = 3,
   parameter int unsigned HA_HOLD       = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [2:0]        mode_i,
   input  logic [SEC_W-1:0]  sec_cnt_i,
   input  logic              word_sent_i,
   input  logic              dev_req_i,
   input  logic              dev_rdy_i,
   input  logic [DATA_W-1:0] crc_i,
   output logic              wr_stb_n_o,
   output logic              ack_n_o,
   output logic              sel0_n_o,
   output logic              sel1_n_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] dout_o,
   output logic              dout_oe_o,
   output logic              done_o
);

   localparam int unsigned HOLD_CYC  = ns2cyc(CRC_HOLD_NS, CLK_PERIOD_NS);
   localparam int unsigned REL_CYC   = ns2cyc(SEL_REL_NS, CLK_PERIOD_NS);
   localparam int unsigned POST_CYC  = umax(HOLD_CYC, REL_CYC);
   localparam int unsigned WORST_PRE = umax(ns2cyc(crc_setup_ns(3'd0), CLK_PERIOD_NS),
                                            ns2cyc(req_ack_ns(3'd0), CLK_PERIOD_NS));
   localparam int unsigned CNT_W     = $clog2(umax(WORST_PRE, POST_CYC) + 1);

   if (CLK_PERIOD_NS == 0) begin : g_bad_period
      $error("udma_wr_term: CLK_PERIOD_NS must be nonzero");
   end
   if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("udma_wr_term: bus widths must be nonzero");
   end
   if (HA_HOLD >= (1 << ADDR_W)) begin : g_bad_addr
      $error("udma_wr_term: HA_HOLD does not fit ADDR_W");
   end

   logic             load;
   logic             data_en;
   logic             last_word;
   logic             empty;
   logic [CNT_W-1:0] pre_cyc;

   udma_mode_timing #(
      .CLK_PERIOD_NS (CLK_PERIOD_NS),
      .CNT_W         (CNT_W)
   ) timing_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .mode_i    (mode_i),
      .pre_cyc_o (pre_cyc)
   );

   udma_byte_counter #(
      .SEC_W (SEC_W)
   ) count_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (load),
      .sec_i   (sec_cnt_i),
      .en_i    (data_en),
      .word_i  (word_sent_i),
      .last_o  (last_word),
      .empty_o (empty)
   );

   udma_term_fsm #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .CNT_W    (CNT_W),
      .HOLD_CYC (HOLD_CYC),
      .POST_CYC (POST_CYC),
      .HA_HOLD  (HA_HOLD)
   ) fsm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .empty_i    (empty),
      .last_i     (last_word),
      .dev_req_i  (dev_req_i),
      .dev_rdy_i  (dev_rdy_i),
      .crc_i      (crc_i),
      .pre_cyc_i  (pre_cyc),
      .load_o     (load),
      .data_en_o  (data_en),
      .wr_stb_n_o (wr_stb_n_o),
      .ack_n_o    (ack_n_o),
      .sel0_n_o   (sel0_n_o),
      .sel1_n_o   (sel1_n_o),
      .addr_o     (addr_o),
      .dout_o     (dout_o),
      .dout_oe_o  (dout_oe_o),
      .done_o     (done_o)
   );

endmodule

// File: tb/udma_wr_term_tb_top.sv
`timescale 1ns/1ps
module udma_wr_term_tb_top;

   localparam int P = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [2:0]  mode_i = 3'd0;
   logic [7:0]  sec_cnt_i = 8'd0;
   logic        word_sent_i = 1'b0;
   logic        dev_req_i = 1'b1;
   logic        dev_rdy_i = 1'b1;
   logic [15:0] crc_i = 16'h0;
   logic        wr_stb_n_o, ack_n_o, sel0_n_o, sel1_n_o, dout_oe_o, done_o;
   logic [2:0]  addr_o;
   logic [15:0] dout_o;

   int n_checks = 0;
   int n_errs = 0;
   int cyc = 0;

   udma_wr_term dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .sec_cnt_i(sec_cnt_i), .word_sent_i(word_sent_i), .dev_req_i(dev_req_i),
      .dev_rdy_i(dev_rdy_i), .crc_i(crc_i), .wr_stb_n_o(wr_stb_n_o),
      .ack_n_o(ack_n_o), .sel0_n_o(sel0_n_o), .sel1_n_o(sel1_n_o),
      .addr_o(addr_o), .dout_o(dout_o), .dout_oe_o(dout_oe_o), .done_o(done_o)
   );

   always #10 clk = ~clk;

   function automatic int up(input int ns);
      return (ns + P - 1) / P;
   endfunction

   function automatic int setup_ns(input int m);
      int t[6] = '{100, 90, 70, 60, 40, 30};
      return t[m];
   endfunction

   function automatic int reqack_ns(input int m);
      int t[6] = '{140, 130, 110, 100, 80, 70};
      return t[m];
   endfunction

   function automatic int pre_len(input int mode);
      int m = (mode > 5) ? 0 : mode;
      int a = up(setup_ns(m));
      int b = up(reqack_ns(m));
      return (a > b) ? a : b;
   endfunction

   localparam int HOLD = (20 + P - 1) / P;
   localparam int POST = ((30 + P - 1) / P > HOLD) ? (30 + P - 1) / P : HOLD;

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Behavioural reference: phase 0 idle, 1 data, 2 device wait, 3 CRC, 4 post.
   int m_ph = 0, m_bytes = 0, m_target = 0, m_wait = 0, m_cnt = 0;
   int m_crc = 0;
   bit m_done = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_crc = 0; m_done = 0;
      end else begin
         m_done = 0;
         case (m_ph)
            0: if (start_i) begin
                  m_wait = pre_len(mode_i);
                  m_target = sec_cnt_i * 512;
                  m_bytes = 0;
                  m_ph = (sec_cnt_i == 0) ? 2 : 1;
               end
            1: if (word_sent_i) begin
                  m_bytes += 2;
                  if (m_bytes == m_target) m_ph = 2;
               end
            2: if (!dev_req_i && !dev_rdy_i) begin
                  m_crc = crc_i; m_cnt = 0; m_ph = 3;
               end
            3: begin
                  m_cnt++;
                  if (m_cnt == m_wait) begin m_ph = 4; m_cnt = 0; end
               end
            default: begin
                  m_cnt++;
                  if (m_cnt == POST) begin m_ph = 0; m_done = 1; m_cnt = 0; end
               end
         endcase
      end
   end

   // Per-cycle comparison and duration monitor, away from the rising edge.
   int mon_pre = 0, mon_hold = 0, mon_post = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         automatic bit eoe = (m_ph == 3) || (m_ph == 4 && m_cnt < HOLD);
         check("R3 wr_stb_n", int'(wr_stb_n_o), (m_ph == 1) ? 0 : 1);
         check("R2/R5 ack_n", int'(ack_n_o), (m_ph >= 1 && m_ph <= 3) ? 0 : 1);
         check("R8 sel0_n", int'(sel0_n_o), (m_ph == 0) ? 1 : 0);
         check("R8 sel1_n", int'(sel1_n_o), (m_ph == 0) ? 1 : 0);
         check("R2 addr", int'(addr_o), (m_ph == 0) ? 0 : 5);
         check("R7 dout_oe", int'(dout_oe_o), int'(eoe));
         check("R4 dout", int'(dout_o), eoe ? m_crc : 0);
         check("R8 done", int'(done_o), int'(m_done));
         if (dout_oe_o && !ack_n_o) mon_pre++;
         if (dout_oe_o && ack_n_o) mon_hold++;
         if (ack_n_o && !sel0_n_o) mon_post++;
      end
   end

   task automatic burst(input int mode, input int sec, input int gap,
                        input int req_dly, input int rdy_dly, input int crc);
      @(negedge clk);
      mon_pre = 0; mon_hold = 0; mon_post = 0;
      dev_req_i = 1; dev_rdy_i = 1;
      start_i = 1; mode_i = 3'(mode); sec_cnt_i = 8'(sec);
      @(negedge clk);
      start_i = 0;
      // r2_ burst lines asserted one cycle after start
      check("R2 ack_n after start", int'(ack_n_o), 0);
      check("R2 sel0_n after start", int'(sel0_n_o), 0);
      for (int w = 0; w < sec * 256; w++) begin
         repeat (gap) @(negedge clk);
         word_sent_i = 1;
         if (w == 7) begin
            start_i = 1; mode_i = 3'd5; sec_cnt_i = 8'd0; // ignored mid-burst (R2)
         end
         @(negedge clk);
         word_sent_i = 0; start_i = 0;
      end
      check("R3 strobe stopped", int'(wr_stb_n_o), 1);
      repeat (req_dly) @(negedge clk);
      dev_req_i = 0;
      word_sent_i = 1; // ignored outside the data phase (R3)
      @(negedge clk);
      word_sent_i = 0;
      crc_i = 16'(crc ^ 16'hFFFF);
      repeat (rdy_dly) @(negedge clk);
      dev_rdy_i = 0; crc_i = 16'(crc);
      while (!done_o) @(negedge clk);
      check((mode > 5) ? "R6 pre-negation cycles" : "R5 pre-negation cycles", mon_pre, pre_len(mode));
      check("R7 hold cycles", mon_hold, HOLD);
      check("R8 release cycles", mon_post, POST);
      check("R4 crc value seen", int'(dout_o), 0);
      dev_req_i = 1; dev_rdy_i = 1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 values held in reset
      check("R1 reset wr_stb_n", int'(wr_stb_n_o), 1);
      check("R1 reset ack_n", int'(ack_n_o), 1);
      check("R1 reset sel", int'({sel0_n_o, sel1_n_o}), 3);
      check("R1 reset oe/done", int'({dout_oe_o, done_o}), 0);
      rst_n = 1;
      @(negedge clk);
      check("R1 idle addr", int'(addr_o), 0);
      check("R1 idle dout", int'(dout_o), 0);
      for (int m = 0; m < 8; m++) begin
         burst(m, 1, 0, m % 3, 2 - (m % 3), 16'hA5C0 + m);
      end
      burst(3, 0, 0, 4, 0, 16'h1234);
      burst(7, 2, 1, 0, 3, 16'hBEEF);
      burst(5, 1, 2, 1, 1, 16'h0F0F);
      repeat (3) @(negedge clk);
      check("R1 idle after bursts", int'({wr_stb_n_o, ack_n_o, sel0_n_o, dout_oe_o}), 4'b1110);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_checks++;
         n_errs++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
         $finish;
      end
   end

endmodule